// File: doc/BRIEF.md
# Punctured Rate-1/4 Convolutional Encoder

This block turns the serial, already scrambled bit stream of one sub-channel into a punctured code stream delivered as bytes. A constraint-length-7 mother encoder makes four coded bits for every input bit. A puncturing stage then decides, bit by bit, which coded bits survive, and a small bit stack packs the survivors into bytes.

A run begins with a one-cycle start pulse. The pulse captures up to four block groups, each with its own 32-bit puncturing pattern and a count of 128-coded-bit blocks, together with a pad length. The block then consumes exactly 32 input bits per block. When the last data bit is in, the block encodes six zero bits by itself to flush the register and keeps only a fixed subset of those 24 tail bits. It then appends the requested zero pad bits so the stream ends on a byte boundary. Choosing the patterns and the pad length is the caller's job.

Top module: `punct_conv_enc`

## Requirements
- R1: While reset is held and after it is released, `byte_vld_o` is 0 and `byte_o` is 0 until a run produces a byte.
- R2: The encoder register clears at each start. For each input bit u, the window is w = {u, six previous inputs, newest first}, so w[6] is the current bit. The coded bits are c0..c3 = parity(w & G) for G = octal 133, 171, 145, 133, taken in that order.
- R3: A run consumes exactly 32 × (sum of group counts) input bits, one per cycle in which `bit_vld_i` is 1. Cycles with `bit_vld_i` at 0 consume nothing. Valid bits offered after the data phase has ended are not consumed.
- R4: Within a block, the four 32-coded-bit sub-blocks all use the same pattern. Pattern bit 31 applies to the first coded bit of a sub-block and bit 0 to the last. A coded bit is kept when its pattern bit is 1 and dropped when it is 0.
- R5: Groups are processed in order 0 to 3. Group g uses count `grp_blocks_i[g*8 +: 8]` and pattern `grp_pat_i[g*32 +: 32]`, both captured at start. Groups with a count of zero are skipped.
- R6: After the data, six zero bits are encoded. Of each four resulting coded bits, c0 and c1 are kept and c2 and c3 are dropped, giving 12 tail bits. The register is all zero after the tail.
- R7: After the tail, `pad_bits_i` zero bits (as captured at start) are appended.
- R8: The first kept bit of a run lands in bit 7 of the first output byte. A byte is emitted, with `byte_vld_o` high for one cycle, as soon as eight bits are held. The stack never holds more than 11 bits.
- R9: While idle, `bit_vld_i` has no effect. A start pulse during a run is ignored, and the run's output is unchanged.
- R10: A run with all group counts zero produces only the 12 zero tail bits plus the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that captures the configuration and begins a run |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| grp_blocks_i | input | NGRP×CNTW (32) | Block count per group, group g at slice g |
| grp_pat_i | input | NGRP×32 (128) | Puncturing pattern per group, group g at slice g |
| pad_bits_i | input | PADW (4) | Number of zero pad bits after the tail |
| byte_o | output | 8 | Packed output byte, first bit in bit 7 |
| byte_vld_o | output | 1 | `byte_o` is new this cycle |

## Verification
The hardest situation to reach is the handover between groups. There, the pattern changes on the very input bit that completes a block, and a zero-count group in between must be jumped over without consuming a bit. The stimulus sets the counts to 2, 0, 1, 3 with four distinct patterns and repeats that run with gaps in `bit_vld_i` and inverted garbage on `bit_i` during the gaps. Any slip in the block counter or the skip logic then shows up as a shifted byte stream against the bench's own model.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int CODE_N  = 4;
  localparam int SR_LEN  = 6;
  localparam int PAT_W   = 32;
  localparam int SUB_IN  = PAT_W / CODE_N;
  localparam int BLK_IN  = SUB_IN * 4;
  localparam int TAIL_N  = SR_LEN;
  localparam logic [CODE_N-1:0][SR_LEN:0] GEN_POLY = {7'o133, 7'o145, 7'o171, 7'o133};
  localparam logic [CODE_N-1:0] TAIL_KEEP = 4'b0011;
  localparam logic [CODE_N-1:0] PAD_KEEP  = 4'b0001;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2,
    PH_PAD  = 2'd3
  } phase_e;
endpackage

// File: rtl/pce_mother_enc.sv
module pce_mother_enc
  import pce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              in_bit_i,
  output logic [CODE_N-1:0] code_o,
  output logic [SR_LEN-1:0] state_o
);
  logic [SR_LEN-1:0] sr_q;
  logic [SR_LEN-1:0] sr_d;
  logic [SR_LEN:0]   win;

  always_comb begin
    win = {in_bit_i, sr_q};
    for (int k = 0; k < CODE_N; k++) begin
      code_o[k] = ^(win & GEN_POLY[k]);
    end
  end

  always_comb begin
    sr_d = sr_q;
    if (clear_i) begin
      sr_d = '0;
    end else if (step_i) begin
      sr_d = win[SR_LEN:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign state_o = sr_q;
endmodule

// File: rtl/pce_sched.sv
module pce_sched
  import pce_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int CNTW = 8,
  parameter int PADW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        bit_i,
  input  logic                        bit_vld_i,
  input  logic [NGRP-1:0][CNTW-1:0]   grp_blocks_i,
  input  logic [NGRP-1:0][PAT_W-1:0]  grp_pat_i,
  input  logic [PADW-1:0]             pad_bits_i,
  output phase_e                      phase_o,
  output logic                        clear_o,
  output logic                        step_o,
  output logic                        enc_bit_o,
  output logic [CODE_N-1:0]           keep_o,
  output logic                        pad_o
);
  localparam int GW    = $clog2(NGRP);
  localparam int POSW  = $clog2(BLK_IN);
  localparam int SUBW  = $clog2(SUB_IN);
  localparam int TW    = $clog2(TAIL_N + 1);
  localparam logic [POSW-1:0] POS_LAST  = POSW'(BLK_IN - 1);
  localparam logic [TW-1:0]   TAIL_LAST = TW'(TAIL_N - 1);

  phase_e                     ph_q, ph_d;
  logic [GW-1:0]              grp_q, grp_d;
  logic [CNTW-1:0]            blk_q, blk_d;
  logic [POSW-1:0]            pos_q, pos_d;
  logic [TW-1:0]              tail_q, tail_d;
  logic [PADW-1:0]            padl_q, padl_d;
  logic [NGRP-1:0][CNTW-1:0]  cnt_q, cnt_d;
  logic [NGRP-1:0][PAT_W-1:0] pat_q, pat_d;

  logic [GW:0]               base;
  logic [NGRP-1:0][CNTW-1:0] cnt_src;
  logic                      nz_found;
  logic [GW-1:0]             nz_idx;
  logic [PAT_W-1:0]          cur_pat;
  logic [CODE_N-1:0]         keep_data;

  // search for the next group with a nonzero count at or above base
  always_comb begin
    base     = (ph_q == PH_IDLE) ? '0 : ({1'b0, grp_q} + 1'b1);
    cnt_src  = (ph_q == PH_IDLE) ? grp_blocks_i : cnt_q;
    nz_found = 1'b0;
    nz_idx   = '0;
    for (int j = NGRP - 1; j >= 0; j--) begin
      if ((j >= int'(base)) && (cnt_src[j] != '0)) begin
        nz_found = 1'b1;
        nz_idx   = GW'(j);
      end
    end
  end

  always_comb begin
    cur_pat = pat_q[grp_q];
    for (int k = 0; k < CODE_N; k++) begin
      keep_data[k] = cur_pat[PAT_W - 1 - (CODE_N * int'(pos_q[SUBW-1:0]) + k)];
    end
  end

  always_comb begin
    ph_d      = ph_q;
    grp_d     = grp_q;
    blk_d     = blk_q;
    pos_d     = pos_q;
    tail_d    = tail_q;
    padl_d    = padl_q;
    cnt_d     = cnt_q;
    pat_d     = pat_q;
    clear_o   = 1'b0;
    step_o    = 1'b0;
    enc_bit_o = 1'b0;
    keep_o    = '0;
    pad_o     = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          cnt_d   = grp_blocks_i;
          pat_d   = grp_pat_i;
          padl_d  = pad_bits_i;
          pos_d   = '0;
          tail_d  = '0;
          clear_o = 1'b1;
          if (nz_found) begin
            ph_d  = PH_DATA;
            grp_d = nz_idx;
            blk_d = grp_blocks_i[nz_idx];
          end else begin
            ph_d = PH_TAIL;
          end
        end
      end
      PH_DATA: begin
        if (bit_vld_i) begin
          step_o    = 1'b1;
          enc_bit_o = bit_i;
          keep_o    = keep_data;
          pos_d     = pos_q + 1'b1;
          if (pos_q == POS_LAST) begin
            if (blk_q == CNTW'(1)) begin
              if (nz_found) begin
                grp_d = nz_idx;
                blk_d = cnt_q[nz_idx];
              end else begin
                ph_d = PH_TAIL;
              end
            end else begin
              blk_d = blk_q - 1'b1;
            end
          end
        end
      end
      PH_TAIL: begin
        step_o = 1'b1;
        keep_o = TAIL_KEEP;
        tail_d = tail_q + 1'b1;
        if (tail_q == TAIL_LAST) begin
          ph_d = (padl_q == '0) ? PH_IDLE : PH_PAD;
        end
      end
      PH_PAD: begin
        pad_o  = 1'b1;
        keep_o = PAD_KEEP;
        padl_d = padl_q - 1'b1;
        if (padl_q == PADW'(1)) begin
          ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      grp_q  <= '0;
      blk_q  <= '0;
      pos_q  <= '0;
      tail_q <= '0;
      padl_q <= '0;
      cnt_q  <= '0;
      pat_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      grp_q  <= grp_d;
      blk_q  <= blk_d;
      pos_q  <= pos_d;
      tail_q <= tail_d;
      padl_q <= padl_d;
      cnt_q  <= cnt_d;
      pat_q  <= pat_d;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/pce_packer.sv
module pce_packer
  import pce_pkg::*;
#(
  parameter int STK = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CODE_N-1:0]       bits_i,
  input  logic [CODE_N-1:0]       keep_i,
  output logic [7:0]              byte_o,
  output logic                    byte_vld_o,
  output logic [$clog2(STK+1)-1:0] fill_o
);
  localparam int FW = $clog2(STK + 1);

  logic [STK-1:0] stk_q, stk_n;
  logic [FW-1:0]  fill_q, fill_n;
  logic [7:0]     byte_q;
  logic           vld_q;
  logic           emit;

  always_comb begin
    emit   = (fill_q >= FW'(8));
    stk_n  = stk_q;
    fill_n = fill_q;
    if (emit) begin
      stk_n  = stk_q << 8;
      fill_n = fill_q - FW'(8);
    end
    for (int k = 0; k < CODE_N; k++) begin
      if (keep_i[k]) begin
        stk_n[STK - 1 - int'(fill_n)] = bits_i[k];
        fill_n = fill_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q  <= '0;
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      stk_q  <= stk_n;
      fill_q <= fill_n;
      vld_q  <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (emit) begin
      byte_q <= stk_q[STK-1 -: 8];
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign fill_o     = fill_q;
endmodule

// File: rtl/punct_conv_enc.sv
module punct_conv_enc
  import pce_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int CNTW = 8,
  parameter int PADW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       bit_i,
  input  logic                       bit_vld_i,
  input  logic [NGRP-1:0][CNTW-1:0]  grp_blocks_i,
  input  logic [NGRP-1:0][PAT_W-1:0] grp_pat_i,
  input  logic [PADW-1:0]            pad_bits_i,
  output logic [7:0]                 byte_o,
  output logic                       byte_vld_o
);
  localparam int STK = 16;
  localparam int FW  = $clog2(STK + 1);

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  phase_e            phase;
  logic              clear;
  logic              step;
  logic              enc_bit;
  logic [CODE_N-1:0] keep;
  logic              pad;
  logic [CODE_N-1:0] code;
  logic [SR_LEN-1:0] enc_state;
  logic [CODE_N-1:0] pk_bits;
  logic [FW-1:0]     fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  pce_sched #(.NGRP(NGRP), .CNTW(CNTW), .PADW(PADW)) u_sched (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .bit_i        (bit_i),
    .bit_vld_i    (bit_vld_i),
    .grp_blocks_i (grp_blocks_i),
    .grp_pat_i    (grp_pat_i),
    .pad_bits_i   (pad_bits_i),
    .phase_o      (phase),
    .clear_o      (clear),
    .step_o       (step),
    .enc_bit_o    (enc_bit),
    .keep_o       (keep),
    .pad_o        (pad)
  );

  pce_mother_enc u_enc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear_i  (clear),
    .step_i   (step),
    .in_bit_i (enc_bit),
    .code_o   (code),
    .state_o  (enc_state)
  );

  assign pk_bits = pad ? '0 : code;

  pce_packer #(.STK(STK)) u_pack (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bits_i     (pk_bits),
    .keep_i     (keep),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .fill_o     (fill)
  );
endmodule

// File: rtl/pce_chk.sv
module pce_chk
  import pce_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic              step,
  input logic [CODE_N-1:0] keep,
  input logic              pk_bit0,
  input logic [SR_LEN-1:0] enc_state,
  input logic [4:0]        fill,
  input logic              byte_vld
);
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (!step && keep == '0)); // R9
  AST_TAIL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TAIL) |-> (step && keep == TAIL_KEEP)); // R6
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_TAIL) && ($past(phase) == PH_TAIL)) |-> (enc_state == '0)); // R6
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAD) |-> (keep == PAD_KEEP && !pk_bit0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 5'd11); // R8
  AST_BYTE_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(fill) >= 5'd8)); // R8
endmodule

bind punct_conv_enc pce_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .phase     (phase),
  .step      (step),
  .keep      (keep),
  .pk_bit0   (pk_bits[0]),
  .enc_state (enc_state),
  .fill      (fill),
  .byte_vld  (byte_vld_o)
);

// File: tb/punct_conv_enc_tb_top.sv
module punct_conv_enc_tb_top;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             bit_i = 1'b0;
  logic             bit_vld_i = 1'b0;
  logic [3:0][7:0]  blocks_drv = '0;
  logic [3:0][31:0] pat_drv = '0;
  logic [3:0]       pad_drv = '0;
  logic [7:0]       byte_o;
  logic             byte_vld_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int          cfg_cnt [4];
  logic [31:0] cfg_pat [4];
  int          cfg_pad;
  bit          q_in [$];
  logic [7:0]  exp_q [$];
  logic [7:0]  got_q [$];
  logic [6:0]  gtab [4] = '{7'o133, 7'o171, 7'o145, 7'o133};
  int unsigned seed = 32'h1234_5678;

  punct_conv_enc dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .bit_i        (bit_i),
    .bit_vld_i    (bit_vld_i),
    .grp_blocks_i (blocks_drv),
    .grp_pat_i    (pat_drv),
    .pad_bits_i   (pad_drv),
    .byte_o       (byte_o),
    .byte_vld_o   (byte_vld_o)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (byte_vld_o) got_q.push_back(byte_o);
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_err++;
      $display("FAIL WDOG timeout actual %0d expected below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic bit rnd_bit();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[7];
  endfunction

  function automatic logic [3:0] code_of(input logic [6:0] w);
    logic [3:0] c;
    for (int k = 0; k < 4; k++) c[k] = ^(w & gtab[k]);
    return c;
  endfunction

  // independent reference: mother code, puncturing, tail, pad, packing
  task automatic build_model();
    bit         kb [$];
    logic [5:0] sr;
    logic [6:0] w;
    logic [3:0] c;
    int         n;
    logic [7:0] b;
    sr = '0;
    n = 0;
    for (int g = 0; g < 4; g++)
      for (int blk = 0; blk < cfg_cnt[g]; blk++)
        for (int i = 0; i < 32; i++) begin
          w = {q_in[n], sr};
          n++;
          c = code_of(w);
          sr = w[6:1];
          for (int k = 0; k < 4; k++)
            if (cfg_pat[g][31 - (4 * (i % 8) + k)]) kb.push_back(c[k]);
        end
    for (int t = 0; t < 6; t++) begin
      w = {1'b0, sr};
      c = code_of(w);
      sr = w[6:1];
      kb.push_back(c[0]);
      kb.push_back(c[1]);
    end
    cfg_pad = (8 - (kb.size() % 8)) % 8;
    for (int p = 0; p < cfg_pad; p++) kb.push_back(1'b0);
    exp_q = {};
    for (int i = 0; i + 8 <= kb.size(); i += 8) begin
      for (int j = 0; j < 8; j++) b[7 - j] = kb[i + j];
      exp_q.push_back(b);
    end
  endtask

  task automatic fill_random();
    int total;
    total = 0;
    for (int g = 0; g < 4; g++) total += 32 * cfg_cnt[g];
    q_in = {};
    for (int i = 0; i < total; i++) q_in.push_back(rnd_bit());
  endtask

  task automatic apply_cfg();
    for (int g = 0; g < 4; g++) begin
      blocks_drv[g] = 8'(cfg_cnt[g]);
      pat_drv[g]    = cfg_pat[g];
    end
    pad_drv = 4'(cfg_pad);
  endtask

  task automatic drive_run(input int gap, input int mid_start);
    got_q = {};
    apply_cfg();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < q_in.size(); i++) begin
      if (gap != 0 && (i % gap) == 1) begin
        bit_vld_i = 1'b0;
        bit_i = ~q_in[i];
        @(negedge clk);
      end
      if (i == mid_start) begin
        start_i = 1'b1;
        blocks_drv = {4{8'd1}};
        pat_drv = '0;
        pad_drv = 4'd7;
      end
      bit_vld_i = 1'b1;
      bit_i = q_in[i];
      @(negedge clk);
      start_i = 1'b0;
    end
    bit_vld_i = 1'b0;
    apply_cfg();
    repeat (40) @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk({req, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({req, " byte value"}, int'(got_q[i]), int'(exp_q[i]));
  endtask

  task automatic t_reset();
    chk("R1 vld in reset", int'(byte_vld_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 vld after reset", int'(byte_vld_o), 0);
    chk("R1 byte after reset", int'(byte_o), 0);
  endtask

  // impulse in one block with every bit kept: checks taps, order, packing
  task automatic t_impulse();
    cfg_cnt = '{1, 0, 0, 0};
    cfg_pat = '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0};
    q_in = {};
    q_in.push_back(1'b1);
    for (int i = 1; i < 32; i++) q_in.push_back(1'b0);
    build_model();
    drive_run(0, -1);
    chk("R2 R8 first byte of impulse", (got_q.size() > 0) ? int'(got_q[0]) : -1, 8'hF6);
    chk("R7 byte count with pad 4", got_q.size(), 18);
    compare("R2 R4 R6 impulse");
  endtask

  task automatic t_groups(input int gap);
    cfg_cnt = '{2, 0, 1, 3};
    cfg_pat = '{32'hEEEE_EEEE, 32'hFFFF_FFFF, 32'hC8C8_8C8C, 32'hA5F0_3C96};
    fill_random();
    build_model();
    drive_run(gap, -1);
    if (gap == 0) begin
      compare("R4 R5 groups");
    end else begin
      bit_vld_i = 1'b1;
      for (int i = 0; i < 10; i++) begin
        bit_i = rnd_bit();
        @(negedge clk);
      end
      bit_vld_i = 1'b0;
      repeat (10) @(negedge clk);
      compare("R3 gaps and extra bits");
    end
  endtask

  task automatic t_empty();
    cfg_cnt = '{0, 0, 0, 0};
    cfg_pat = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    q_in = {};
    build_model();
    chk("R10 pad needed", cfg_pad, 4);
    drive_run(0, -1);
    chk("R10 empty byte count", got_q.size(), 2);
    compare("R10 empty");
  endtask

  task automatic t_ignore();
    got_q = {};
    bit_vld_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      bit_i = rnd_bit();
      @(negedge clk);
    end
    bit_vld_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 no bytes while idle", got_q.size(), 0);
    cfg_cnt = '{0, 2, 0, 0};
    cfg_pat = '{32'h0, 32'hF0F0_AAAA, 32'h0, 32'h0};
    fill_random();
    build_model();
    drive_run(0, 12);
    compare("R9 start during run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_impulse();
    t_groups(0);
    t_groups(5);
    t_empty();
    t_ignore();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule